// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Generator

This block forms the partial products of a decimal multiplication. It takes a multiplicand of `DIGITS` decimal digits, each coded with bit weights 4,2,2,1, and a multiplier of `DIGITS` plain BCD digits. It returns `DIGITS+1` partial product rows, each `DIGITS+1` digits wide, plus one extra bit per row. Row k carries weight 10^k. The reduction stage that follows lines the rows up by digit offset and sums them.

Each multiplier digit is recoded into a signed digit between -5 and +5. Because of this, only five multiples of the multiplicand are needed. They are built once and shared by all rows. The doubled and quintupled multiples come from code conversion and fixed bit shifts alone. Only the tripled multiple needs a carry-propagating decimal add.

A row whose digit is negative is the bitwise inverse of the selected multiple, which is its nines complement. The matching +1 is not added into the row. It is presented as a separate hot-one bit at the row's least significant position. The block is purely combinational.

Top module: `sd10_ppgen`

## Requirements
- R1: Multiplier digits are recoded from least significant upward. Let t be the BCD digit plus an incoming carry, with a carry of 0 into digit 0. When t is 5 or more, the signed digit is t-10 and a carry of 1 passes on; otherwise the signed digit is t and the carry is 0. The carry out of the top digit is the signed digit of row `DIGITS`. A signed digit of 0 always counts as positive.
- R2: Each row's magnitude comes from a one-hot choice among 1X, 2X, 3X, 4X and 5X of the multiplicand, so the row equals exactly one multiple.
- R3: A row whose signed digit is 0 is all zero bits and its hot-one bit is 0.
- R4: A row with a positive signed digit m holds m·X. Its digits are decoded by weights 4,2,2,1 on bits 3..0, with digit j at bits 4j+3..4j. Its hot-one bit is 0 and its top digit is at most 4.
- R5: A row with a negative signed digit -m has its hot-one bit set. The row's decoded value plus 1 equals 10^(DIGITS+1) - m·X, and its top digit is at least 5.
- R6: Row `DIGITS` is never negated (hot-one bit `DIGITS` is 0) and it selects either nothing or 1X.
- R7: Each row k contributes (row value, plus its hot-one bit, minus 10^(DIGITS+1) when that bit is set) times 10^k. The sum of these contributions over all rows equals X·Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xIn | input | 4*DIGITS | Multiplicand, one 4,2,2,1-weighted digit per nibble, least significant nibble first |
| yIn | input | 4*DIGITS | Multiplier, BCD digits 0..9, least significant nibble first |
| ppRows | output | (DIGITS+1)*4*(DIGITS+1) | Row k at bits k*4*(DIGITS+1) upward, each with DIGITS+1 digits weighted 4,2,2,1 |
| hotOne | output | DIGITS+1 | Bit k is the +1 that completes the tens complement of row k |

## Verification
The bound checker watches every settled input combination for four properties. Each row's multiple select has at most one bit set. A negation never occurs without a selected multiple. An unselected row is zero with no hot one. The top digit of every row lies on the correct side of 5 for its sign. It also checks that the top row is never negated. Whether a row holds the right multiple, and whether the recoding carries pass correctly between digits, can only be shown by the bench. The bench decodes each row by its weights and compares the row and the weighted sum against its own recoding and product for table, directed and random operands.

// File: rtl/sdpp_pkg.sv
`timescale 1ns/1ps
package sdpp_pkg;

  // Per-row strobes from the recoder to the datapath.
  typedef struct packed {
    logic [4:0] pick;  // one-hot: bit n selects (n+1)·X
    logic       neg;   // invert the selected multiple
  } rowCtl_t;

  // Value of a digit coded with weights 4,2,2,1.
  function automatic logic [3:0] val4221(input logic [3:0] c);
    return {c[3], 2'b00} + {2'b00, c[2], 1'b0} + {2'b00, c[1], 1'b0} + {3'b000, c[0]};
  endfunction

  // Value of a digit coded with weights 5,2,1,1.
  function automatic logic [3:0] val5211(input logic [3:0] c);
    return {c[3], 2'b00} + {3'b000, c[3]} + {2'b00, c[2], 1'b0} + {3'b000, c[1]} + {3'b000, c[0]};
  endfunction

  // Canonical 4,2,2,1 code for a value 0..9.
  function automatic logic [3:0] enc4221(input logic [3:0] v);
    case (v)
      4'd0: return 4'b0000;
      4'd1: return 4'b0001;
      4'd2: return 4'b0010;
      4'd3: return 4'b0011;
      4'd4: return 4'b1000;
      4'd5: return 4'b1001;
      4'd6: return 4'b1010;
      4'd7: return 4'b1011;
      4'd8: return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  // 5,2,1,1 code whose lower three bits carry v mod 5, so a one-bit
  // left shift doubles the digit into 4,2,2,1.
  function automatic logic [3:0] enc5211(input logic [3:0] v);
    case (v)
      4'd0: return 4'b0000;
      4'd1: return 4'b0001;
      4'd2: return 4'b0100;
      4'd3: return 4'b0101;
      4'd4: return 4'b0111;
      4'd5: return 4'b1000;
      4'd6: return 4'b1001;
      4'd7: return 4'b1100;
      4'd8: return 4'b1101;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/sdpp_recode.sv
`timescale 1ns/1ps
module sdpp_recode import sdpp_pkg::*; #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] yIn,
  output rowCtl_t             rowCtl [DIGITS:0]
);

  always_comb begin : recodeLoop
    logic [4:0] t;
    logic [3:0] mag;
    logic       cy;
    cy = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      t = {1'b0, yIn[4*i +: 4]} + {4'b0000, cy};
      if (t >= 5'd5) begin
        mag = 4'(5'd10 - t);
        cy  = 1'b1;
      end else begin
        mag = t[3:0];
        cy  = 1'b0;
      end
      rowCtl[i].neg  = (t >= 5'd5) && (mag != 4'd0);
      rowCtl[i].pick = (mag == 4'd0) ? 5'b00000 : 5'(5'b00001 << (mag - 4'd1));
    end
    rowCtl[DIGITS].neg  = 1'b0;
    rowCtl[DIGITS].pick = {4'b0000, cy};
  end

endmodule

// File: rtl/sdpp_decadd.sv
`timescale 1ns/1ps
module sdpp_decadd import sdpp_pkg::*; #(
  parameter int DIGITS = 5
) (
  input  logic [4*DIGITS-1:0] aIn,
  input  logic [4*DIGITS-1:0] bIn,
  output logic [4*DIGITS-1:0] sumOut
);

  // Ripple decimal add; the caller guarantees no carry out of the top.
  always_comb begin : ripple
    logic [4:0] s;
    logic       cy;
    cy = 1'b0;
    for (int g = 0; g < DIGITS; g++) begin
      s = {1'b0, val4221(aIn[4*g +: 4])} + {1'b0, val4221(bIn[4*g +: 4])} + {4'b0000, cy};
      if (s >= 5'd10) begin
        s  = s - 5'd10;
        cy = 1'b1;
      end else begin
        cy = 1'b0;
      end
      sumOut[4*g +: 4] = enc4221(s[3:0]);
    end
  end

endmodule

// File: rtl/sdpp_datapath.sv
`timescale 1ns/1ps
module sdpp_datapath import sdpp_pkg::*; #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0]            xIn,
  input  rowCtl_t                        rowCtl [DIGITS:0],
  output logic [(DIGITS+1)*4*(DIGITS+1)-1:0] ppRows,
  output logic [DIGITS:0]                hotOne
);

  localparam int WD   = DIGITS + 1;
  localparam int ROWW = 4 * WD;

  logic [ROWW-1:0] mult1, mult2, mult3, mult4, mult5;
  logic [ROWW-1:0] x1as5211, x2as5211, x5as5211;

  assign mult1 = {4'b0000, xIn};

  // Doubling: recode each digit to 5,2,1,1 then shift the vector left one bit.
  for (genvar g = 0; g < WD; g++) begin : g_dbl
    assign x1as5211[4*g +: 4] = enc5211(val4221(mult1[4*g +: 4]));
    assign x2as5211[4*g +: 4] = enc5211(val4221(mult2[4*g +: 4]));
  end
  assign mult2 = {x1as5211[ROWW-2:0], 1'b0};
  assign mult4 = {x2as5211[ROWW-2:0], 1'b0};

  // Quintupling: a three-bit left shift of 4,2,2,1 reads as 5,2,1,1.
  assign x5as5211 = {mult1[ROWW-4:0], 3'b000};
  for (genvar g = 0; g < WD; g++) begin : g_quint
    assign mult5[4*g +: 4] = enc4221(val5211(x5as5211[4*g +: 4]));
  end

  // Tripling needs one carry-propagating add.
  sdpp_decadd #(.DIGITS(WD)) add3_i (
    .aIn   (mult1),
    .bIn   (mult2),
    .sumOut(mult3)
  );

  // One AND-OR select and conditional inversion per row.
  for (genvar k = 0; k <= DIGITS; k++) begin : g_row
    logic [ROWW-1:0] rowMag;
    assign rowMag = ({ROWW{rowCtl[k].pick[0]}} & mult1)
                  | ({ROWW{rowCtl[k].pick[1]}} & mult2)
                  | ({ROWW{rowCtl[k].pick[2]}} & mult3)
                  | ({ROWW{rowCtl[k].pick[3]}} & mult4)
                  | ({ROWW{rowCtl[k].pick[4]}} & mult5);
    assign ppRows[k*ROWW +: ROWW] = rowMag ^ {ROWW{rowCtl[k].neg}};
    assign hotOne[k] = rowCtl[k].neg;
  end

endmodule

// File: rtl/sd10_ppgen.sv
`timescale 1ns/1ps
module sd10_ppgen import sdpp_pkg::*; #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0]                 xIn,
  input  logic [4*DIGITS-1:0]                 yIn,
  output logic [(DIGITS+1)*4*(DIGITS+1)-1:0]  ppRows,
  output logic [DIGITS:0]                     hotOne
);

  rowCtl_t rowCtl [DIGITS:0];

  sdpp_recode #(.DIGITS(DIGITS)) ctl_i (
    .yIn   (yIn),
    .rowCtl(rowCtl)
  );

  sdpp_datapath #(.DIGITS(DIGITS)) dp_i (
    .xIn   (xIn),
    .rowCtl(rowCtl),
    .ppRows(ppRows),
    .hotOne(hotOne)
  );

endmodule

// File: rtl/sd10_ppgen_chk.sv
`timescale 1ns/1ps
module sd10_ppgen_chk import sdpp_pkg::*; #(
  parameter int DIGITS = 4
) (
  input logic [4*DIGITS-1:0]                 xIn,
  input logic [4*DIGITS-1:0]                 yIn,
  input rowCtl_t                             rowCtl [DIGITS:0],
  input logic [(DIGITS+1)*4*(DIGITS+1)-1:0]  ppRows,
  input logic [DIGITS:0]                     hotOne
);

  localparam int ROWW = 4 * (DIGITS + 1);

  for (genvar k = 0; k <= DIGITS; k++) begin : g_chk
    always_comb begin
      if (!$isunknown({xIn, yIn})) begin
        assert_pick_onehot_R2: assert ($onehot0(rowCtl[k].pick))
          else $error("row %0d select not one-hot", k);
        assert_neg_nonzero_R1: assert (!rowCtl[k].neg || (rowCtl[k].pick != 5'b00000))
          else $error("row %0d negated with zero digit", k);
        assert_zero_row_R3: assert ((rowCtl[k].pick != 5'b00000)
                                    || ((ppRows[k*ROWW +: ROWW] == '0) && !hotOne[k]))
          else $error("row %0d not cleared for zero digit", k);
        assert_pos_top_R4: assert (hotOne[k] || (val4221(ppRows[k*ROWW+ROWW-4 +: 4]) <= 4'd4))
          else $error("row %0d positive top digit too large", k);
        assert_neg_top_R5: assert (!hotOne[k] || (val4221(ppRows[k*ROWW+ROWW-4 +: 4]) >= 4'd5))
          else $error("row %0d negative top digit too small", k);
      end
    end
  end

  always_comb begin
    if (!$isunknown(yIn)) begin
      assert_top_row_R6: assert (!hotOne[DIGITS] && (rowCtl[DIGITS].pick[4:1] == 4'b0000))
        else $error("top row negated or selects a large multiple");
    end
  end

endmodule

bind sd10_ppgen sd10_ppgen_chk #(.DIGITS(DIGITS)) chk_i (
  .xIn   (xIn),
  .yIn   (yIn),
  .rowCtl(rowCtl),
  .ppRows(ppRows),
  .hotOne(hotOne)
);

// File: tb/sd10_ppgen_tb_top.sv
`timescale 1ns/1ps
module sd10_ppgen_tb_top;

  localparam int DIGITS = 4;
  localparam int WD     = DIGITS + 1;
  localparam int ROWW   = 4 * WD;
  localparam longint ROWMOD = 100000;  // 10^(DIGITS+1)

  // x, y, expected product
  localparam longint TAB [0:7][0:2] = '{
    '{1234, 5678, 7006652},
    '{9999, 9999, 99980001},
    '{5555, 5555, 30858025},
    '{0,    7777, 0},
    '{4321, 0,    0},
    '{1,    9,    9},
    '{9999, 1,    9999},
    '{6789, 4050, 27495450}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [4*DIGITS-1:0]    xIn, yIn;
  logic [WD*ROWW-1:0]     ppRows;
  logic [DIGITS:0]        hotOne;

  int nRun = 0;
  int nFail = 0;

  sd10_ppgen #(.DIGITS(DIGITS)) dut_i (
    .xIn   (xIn),
    .yIn   (yIn),
    .ppRows(ppRows),
    .hotOne(hotOne)
  );

  // A different, still valid, 4,2,2,1 code set for the multiplicand.
  function automatic logic [3:0] encAlt(input int v);
    case (v)
      0: return 4'b0000;  1: return 4'b0001;  2: return 4'b0100;
      3: return 4'b0101;  4: return 4'b0110;  5: return 4'b0111;
      6: return 4'b1100;  7: return 4'b1101;  8: return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [4*DIGITS-1:0] encX(input longint v);
    logic [4*DIGITS-1:0] r;
    longint t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = encAlt(int'(t % 10));
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [4*DIGITS-1:0] encY(input longint v);
    logic [4*DIGITS-1:0] r;
    longint t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic longint digVal(input logic [3:0] c);
    return 4 * longint'(c[3]) + 2 * longint'(c[2]) + 2 * longint'(c[1]) + longint'(c[0]);
  endfunction

  function automatic longint decRow(input logic [ROWW-1:0] w);
    longint acc = 0;
    for (int j = WD - 1; j >= 0; j--) acc = acc * 10 + digVal(w[4*j +: 4]);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runCase(input longint x, input longint y, input longint expP);
    longint sd [0:DIGITS];
    longint c = 0;
    longint total = 0;
    longint scale = 1;
    @(negedge clk);
    xIn = encX(x);
    yIn = encY(y);
    @(posedge clk);
    #2;
    // own recoding of the multiplier (R1)
    for (int k = 0; k < DIGITS; k++) begin
      longint t = ((y / (scale)) % 10) + c;
      scale = scale * 10;
      if (t >= 5) begin sd[k] = t - 10; c = 1; end
      else begin sd[k] = t; c = 0; end
    end
    sd[DIGITS] = c;
    scale = 1;
    for (int k = 0; k <= DIGITS; k++) begin
      logic [ROWW-1:0] row = ppRows[k*ROWW +: ROWW];
      longint rv  = decRow(row);
      longint top = digVal(row[ROWW-4 +: 4]);
      bit h = hotOne[k];
      if (sd[k] == 0) begin
        check(row == '0 && !h, "R3 zero row", rv, 0);
      end else if (sd[k] > 0) begin
        check(!h && rv == sd[k] * x && top <= 4, "R1 R2 R4 positive row", rv, sd[k] * x);
      end else begin
        check(h && rv + 1 == ROWMOD + sd[k] * x && top >= 5, "R1 R2 R5 negative row",
              rv + 1, ROWMOD + sd[k] * x);
      end
      total += (h ? rv + 1 - ROWMOD : rv) * scale;
      scale = scale * 10;
    end
    check(!hotOne[DIGITS], "R6 top row sign", longint'(hotOne[DIGITS]), 0);
    check(total == x * y && total == expP, "R7 weighted sum", total, expP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    xIn = '0;
    yIn = '0;
    repeat (3) @(posedge clk);
    #2;
    check(ppRows == '0 && hotOne == '0, "R3 idle outputs under reset", longint'(hotOne), 0);
    rstN = 1'b1;

    // table walk
    for (int v = 0; v < 8; v++) runCase(TAB[v][0], TAB[v][1], TAB[v][2]);

    // directed corners: every digit negative, carry into digit 10 (zero), five boundary
    runCase(9999, 6666, 9999 * 6666);
    runCase(9999, 9595, 9999 * 9595);
    runCase(8888, 4444, 8888 * 4444);
    runCase(1111, 5000, 1111 * 5000);
    runCase(9999, 5, 9999 * 5);
    runCase(7, 9990, 7 * 9990);

    // random operands
    for (int r = 0; r < 300; r++) begin
      longint x = longint'($urandom % 10000);
      longint y = longint'($urandom % 10000);
      runCase(x, y, x * y);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule